// File: doc/BRIEF.md
# Retire-Counted Time Base with Read Decode

This block holds a 64-bit time base and decodes the instruction that reads it. Each cycle it takes a 32-bit instruction word and a retire strobe. When the word is the move-from-time-base instruction and the strobe is high, the block returns one 32-bit half of the counter, the destination register index taken from the word, and a valid flag. The selector field in the word arrives with its two 5-bit groups exchanged, so the block puts them back in order before it compares the result against the two defined selector numbers. Any other selector reads as zero.

The counter does not follow the clock. It advances by one for every retired instruction, whatever that instruction is, so the same instruction trace always gives the same readings. A separate write port can load either half of the counter, but only when the privilege input is high. A write attempt without privilege leaves the counter unchanged, and a small two-state controller raises a fault flag for the next cycle. The controller has two states. `WRC_IDLE` is the normal state. It moves to `WRC_FAULT` on a rejected write (transition *reject*). `WRC_FAULT` returns to `WRC_IDLE` when a cycle has no rejected write (transition *clear*), and it stays in `WRC_FAULT` while rejected writes keep arriving (transition *repeat*).

Top module: `tbase_reader`

## Requirements
- R1: `rd_valid_o` is 1 exactly when `retire_i` is 1, `insn_i[31:26]` equals 31 and `insn_i[10:1]` equals 371. Bit `insn_i[0]` is ignored. While `rd_valid_o` is 0, `rd_data_o` and `rd_idx_o` are 0.
- R2: While `rd_valid_o` is 1, `rd_idx_o` equals `insn_i[25:21]`.
- R3: The selector number is `{insn_i[15:11], insn_i[20:16]}`. Selector 268 returns counter bits 31:0.
- R4: Selector 269 returns counter bits 63:32.
- R5: Any other selector gives a valid read with `rd_data_o` equal to 0.
- R6: The counter grows by exactly one at each clock edge where `retire_i` is 1 and no privileged write happens, for any instruction word. It holds its value when `retire_i` is 0. A read returns the value from before its own increment.
- R7: A carry out of the low half in a reading cycle appears in the upper half only on a later read. The counter wraps from all ones to zero and raises no flag.
- R8: A privileged write (`wr_en_i`=1, `priv_i`=1) loads `wr_data_i` into the upper half when `wr_hi_i`=1 and into the lower half when `wr_hi_i`=0. The other half is unchanged. The write takes priority over a retire in the same cycle, and that increment is dropped.
- R9: An unprivileged write (`wr_en_i`=1, `priv_i`=0) changes no counter bit, and `wr_fault_o` is 1 in the following cycle only.
- R10: A synchronous reset clears the counter to zero and `wr_fault_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_i | input | 32 | Instruction word of the retiring instruction |
| retire_i | input | 1 | One instruction retires this cycle |
| wr_en_i | input | 1 | Write request for a counter half |
| wr_hi_i | input | 1 | Write target: 1 upper half, 0 lower half |
| wr_data_i | input | 32 | Write data |
| priv_i | input | 1 | The requester holds privilege |
| rd_data_o | output | 32 | Selected counter half, or zero |
| rd_idx_o | output | 5 | Destination register index |
| rd_valid_o | output | 1 | A time-base read is being returned |
| wr_fault_o | output | 1 | Rejected write in the previous cycle |

## Verification
The hardest cases to reach from the ports are the counter rollovers. Reaching them by counting retires would take about four billion cycles. The bench instead uses privileged writes to place the counter one or two counts below a carry. It then retires reads, so the carry from the low half into the upper half, and the full wrap to zero, happen within a few cycles. Each reading is compared with a model in the bench that adds one per retire. The same write port also sets up the case where a write and a retire arrive in the same cycle, which shows the dropped increment.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    // Instruction field constants (word bit 31 is the leftmost instruction bit)
    localparam int unsigned INSN_W      = 32;
    localparam int unsigned PRIM_OP     = 31;
    localparam int unsigned EXT_OP      = 371;
    localparam int unsigned SEL_W       = 10;
    localparam int unsigned IDX_W       = 5;
    localparam int unsigned SEL_LOW_NUM = 268;
    localparam int unsigned SEL_UP_NUM  = 269;

    typedef enum logic [1:0] {
        SELK_NONE = 2'd0,
        SELK_LOW  = 2'd1,
        SELK_UP   = 2'd2,
        SELK_ZERO = 2'd3
    } sel_kind_t;

    typedef enum logic {
        WRC_IDLE  = 1'b0,
        WRC_FAULT = 1'b1
    } wrc_state_t;

    // Restore the selector order: second 5-bit group becomes the upper part
    function automatic logic [SEL_W-1:0] unswap_sel(input logic [SEL_W-1:0] raw);
        return {raw[SEL_W/2-1:0], raw[SEL_W-1:SEL_W/2]};
    endfunction

endpackage

// File: rtl/tbase_decode.sv
module tbase_decode
    import tbase_pkg::*;
(
    input  logic [INSN_W-1:1] insn_i,
    input  logic              retire_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output sel_kind_t         kind_o
);
    localparam int unsigned PO_W = 6;
    localparam int unsigned XO_W = 10;

    logic [PO_W-1:0]  prim;
    logic [XO_W-1:0]  ext;
    logic [SEL_W-1:0] sel_raw;
    logic [SEL_W-1:0] sel_num;
    logic             match;

    always_comb begin
        prim    = insn_i[31:26];
        ext     = insn_i[10:1];
        sel_raw = insn_i[20:11];
        sel_num = unswap_sel(sel_raw);
        match   = (prim == PO_W'(PRIM_OP)) && (ext == XO_W'(EXT_OP));
        hit_o   = retire_i && match;
        idx_o   = hit_o ? insn_i[25:21] : '0;
    end

    always_comb begin
        if (!hit_o)
            kind_o = SELK_NONE;
        else if (sel_num == SEL_W'(SEL_LOW_NUM))
            kind_o = SELK_LOW;
        else if (sel_num == SEL_W'(SEL_UP_NUM))
            kind_o = SELK_UP;
        else
            kind_o = SELK_ZERO;
    end
endmodule

// File: rtl/tbase_wrctl.sv
module tbase_wrctl
    import tbase_pkg::*;
#(
    parameter int unsigned NHALF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic             wr_hi_i,
    input  logic             priv_i,
    output logic [NHALF-1:0] load_o,
    output logic             fault_o
);
    wrc_state_t state_q, state_d;
    logic       reject;

    assign reject = wr_en_i && !priv_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WRC_IDLE:  state_d = reject ? WRC_FAULT : WRC_IDLE;   // reject
            WRC_FAULT: state_d = reject ? WRC_FAULT : WRC_IDLE;   // repeat / clear
            default:   state_d = WRC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= WRC_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        fault_o = 1'b0;
        unique case (state_q)
            WRC_IDLE:  fault_o = 1'b0;
            WRC_FAULT: fault_o = 1'b1;
            default:   fault_o = 1'b0;
        endcase
        for (int h = 0; h < NHALF; h++)
            load_o[h] = wr_en_i && priv_i && (int'(wr_hi_i) == h);
    end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int unsigned TB_W  = 64,
    parameter int unsigned NHALF = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   inc_i,
    input  logic [NHALF-1:0]       load_i,
    input  logic [TB_W/NHALF-1:0]  data_i,
    output logic [TB_W-1:0]        tb_o
);
    localparam int unsigned HALF_W = TB_W / NHALF;

    logic [TB_W-1:0] tb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q <= '0;
        end else if (|load_i) begin
            for (int h = 0; h < NHALF; h++)
                if (load_i[h]) tb_q[h*HALF_W +: HALF_W] <= data_i;
        end else if (inc_i) begin
            tb_q <= tb_q + TB_W'(1);
        end
    end

    assign tb_o = tb_q;
endmodule

// File: rtl/tbase_reader.sv
module tbase_reader
    import tbase_pkg::*;
#(
    parameter int unsigned TB_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [31:0]          insn_i,
    input  logic                 retire_i,
    input  logic                 wr_en_i,
    input  logic                 wr_hi_i,
    input  logic [TB_W/2-1:0]    wr_data_i,
    input  logic                 priv_i,
    output logic [TB_W/2-1:0]    rd_data_o,
    output logic [IDX_W-1:0]     rd_idx_o,
    output logic                 rd_valid_o,
    output logic                 wr_fault_o
);
    localparam int unsigned NHALF  = 2;
    localparam int unsigned HALF_W = TB_W / NHALF;

    logic             hit;
    logic [IDX_W-1:0] idx;
    sel_kind_t        kind;
    logic [NHALF-1:0] load;
    logic [TB_W-1:0]  tb_val;
    logic             unused_resv;

    assign unused_resv = insn_i[0];

    tbase_decode u_dec (
        .insn_i   (insn_i[31:1]),
        .retire_i (retire_i),
        .hit_o    (hit),
        .idx_o    (idx),
        .kind_o   (kind)
    );

    tbase_wrctl #(.NHALF(NHALF)) u_wrc (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en_i),
        .wr_hi_i (wr_hi_i),
        .priv_i  (priv_i),
        .load_o  (load),
        .fault_o (wr_fault_o)
    );

    tbase_counter #(.TB_W(TB_W), .NHALF(NHALF)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (retire_i),
        .load_i (load),
        .data_i (wr_data_i),
        .tb_o   (tb_val)
    );

    always_comb begin
        rd_valid_o = hit;
        rd_idx_o   = idx;
        unique case (kind)
            SELK_LOW:  rd_data_o = tb_val[HALF_W-1:0];
            SELK_UP:   rd_data_o = tb_val[TB_W-1:HALF_W];
            SELK_ZERO: rd_data_o = '0;
            SELK_NONE: rd_data_o = '0;
            default:   rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/tbase_reader_chk.sv
module tbase_reader_chk #(
    parameter int unsigned TB_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       insn_i,
    input logic              retire_i,
    input logic              wr_en_i,
    input logic              wr_hi_i,
    input logic [TB_W/2-1:0] wr_data_i,
    input logic              priv_i,
    input logic [TB_W/2-1:0] rd_data_o,
    input logic [4:0]        rd_idx_o,
    input logic              rd_valid_o,
    input logic              wr_fault_o,
    input logic [TB_W-1:0]   tb
);
    localparam int unsigned HW = TB_W / 2;

    logic [9:0] sel_seen;
    assign sel_seen = {insn_i[15:11], insn_i[20:16]};

    a_r1_valid_needs_retire: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> retire_i);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_valid_o |-> (rd_data_o == '0 && rd_idx_o == '0));

    a_r2_index: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> rd_idx_o == insn_i[25:21]);

    a_r5_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && sel_seen != 10'd268 && sel_seen != 10'd269) |-> rd_data_o == '0);

    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !wr_en_i) |=> tb == $past(tb) + TB_W'(1));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!retire_i && !wr_en_i) |=> $stable(tb));

    a_r8_load_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && priv_i && !wr_hi_i) |=>
            (tb[HW-1:0] == $past(wr_data_i) && tb[TB_W-1:HW] == $past(tb[TB_W-1:HW])));

    a_r8_load_up: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && priv_i && wr_hi_i) |=>
            (tb[TB_W-1:HW] == $past(wr_data_i) && tb[HW-1:0] == $past(tb[HW-1:0])));

    a_r9_fault_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !priv_i) |=> wr_fault_o);

    a_r9_no_spurious_fault: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && !priv_i) |=> !wr_fault_o);

    a_r9_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !priv_i && !retire_i) |=> $stable(tb));

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (tb == '0 && !wr_fault_o));
endmodule

bind tbase_reader tbase_reader_chk #(.TB_W(TB_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_i     (insn_i),
    .retire_i   (retire_i),
    .wr_en_i    (wr_en_i),
    .wr_hi_i    (wr_hi_i),
    .wr_data_i  (wr_data_i),
    .priv_i     (priv_i),
    .rd_data_o  (rd_data_o),
    .rd_idx_o   (rd_idx_o),
    .rd_valid_o (rd_valid_o),
    .wr_fault_o (wr_fault_o),
    .tb         (tb_val)
);

// File: tb/sim_tbase_reader.sv
module sim_tbase_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn_i = '0;
    logic        retire_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_hi_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        priv_i = 1'b0;
    logic [31:0] rd_data_o;
    logic [4:0]  rd_idx_o;
    logic        rd_valid_o;
    logic        wr_fault_o;

    int checks = 0;
    int failures = 0;
    logic [63:0] model = '0;

    always #5 clk = ~clk;

    tbase_reader u0 (
        .clk(clk), .rst(rst), .insn_i(insn_i), .retire_i(retire_i),
        .wr_en_i(wr_en_i), .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i),
        .priv_i(priv_i), .rd_data_o(rd_data_o), .rd_idx_o(rd_idx_o),
        .rd_valid_o(rd_valid_o), .wr_fault_o(wr_fault_o)
    );

    // kinds: 0 not recognised, 1 low half, 2 upper half, 3 zero
    localparam int NV = 9;
    localparam logic [31:0] V_INSN [NV] = '{
        32'h7CAC42E6, 32'h7FED42E6, 32'h7C0002E6, 32'h7C6E42E6, 32'h7C4862E6,
        32'h7CAC42A6, 32'h78AC42E6, 32'h7CAC42E7, 32'h7E2D42E6 };
    localparam logic [1:0] V_KIND [NV] = '{
        2'd1, 2'd2, 2'd3, 2'd3, 2'd3, 2'd0, 2'd0, 2'd1, 2'd2 };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] insn, input logic ret, input logic wen,
                         input logic whi, input logic [31:0] wd, input logic pv);
        @(negedge clk);
        insn_i = insn; retire_i = ret; wr_en_i = wen; wr_hi_i = whi;
        wr_data_i = wd; priv_i = pv;
        #1;
    endtask

    task automatic idle();
        drive(32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic read_half(input logic up, input string req, input logic [31:0] exp);
        drive(up ? 32'h7C2D42E6 : 32'h7C2C42E6, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0);
        chk(req, {32'h0, rd_data_o}, {32'h0, exp});
        model = model + 64'd1;
    endtask

    task automatic pwrite(input logic up, input logic [31:0] d);
        drive(32'h0, 1'b0, 1'b1, up, d, 1'b1);
        if (up) model[63:32] = d; else model[31:0] = d;
    endtask

    initial begin
        #(200000 * 10);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R10: reset state
        chk("R10 fault after reset", {63'h0, wr_fault_o}, 64'h0);
        read_half(1'b0, "R10 low after reset", 32'h0);
        read_half(1'b1, "R10 up after reset", 32'h0);

        pwrite(1'b1, 32'h12345678);
        pwrite(1'b0, 32'h9ABCDEF0);

        // table walk, R1-style recognition, R2, R3, R4, R5, R6
        for (int i = 0; i < NV; i++) begin
            drive(V_INSN[i], 1'b1, 1'b0, 1'b0, 32'h0, 1'b0);
            chk("R1 valid", {63'h0, rd_valid_o}, {63'h0, V_KIND[i] != 2'd0});
            chk("R2 index", {59'h0, rd_idx_o}, V_KIND[i] != 2'd0 ? {59'h0, V_INSN[i][25:21]} : 64'h0);
            case (V_KIND[i])
                2'd1: chk("R3 low half", {32'h0, rd_data_o}, {32'h0, model[31:0]});
                2'd2: chk("R4 upper half", {32'h0, rd_data_o}, {32'h0, model[63:32]});
                default: chk("R5 zero data", {32'h0, rd_data_o}, 64'h0);
            endcase
            model = model + 64'd1;  // R6: every retire counts
        end
        read_half(1'b0, "R6 count after table", 32'h9ABCDEF0 + NV);

        // R6: no retire, no increment; matching word without retire is not valid
        drive(32'h7CAC42E6, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        chk("R1 no retire no valid", {63'h0, rd_valid_o}, 64'h0);
        idle();
        read_half(1'b0, "R6 hold without retire", model[31:0]);

        // R7: carry from low into upper half visible on next read
        pwrite(1'b1, 32'h00000007);
        pwrite(1'b0, 32'hFFFFFFFF);
        read_half(1'b0, "R7 low before carry", 32'hFFFFFFFF);
        read_half(1'b1, "R7 upper after carry", 32'h00000008);

        // R7: full wrap to zero
        pwrite(1'b1, 32'hFFFFFFFF);
        pwrite(1'b0, 32'hFFFFFFFE);
        read_half(1'b0, "R7 near wrap", 32'hFFFFFFFE);
        read_half(1'b0, "R7 at all ones", 32'hFFFFFFFF);
        read_half(1'b1, "R7 wrapped upper", 32'h0);
        read_half(1'b0, "R7 wrapped low", 32'h00000001);

        // R8: write beats retire in same cycle
        drive(32'h7CAC42E6, 1'b1, 1'b1, 1'b0, 32'h00000100, 1'b1);
        model[31:0] = 32'h00000100;
        read_half(1'b0, "R8 write priority", 32'h00000100);
        read_half(1'b1, "R8 other half kept", model[63:32]);

        // R9: unprivileged write ignored, fault for one cycle
        drive(32'h0, 1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 1'b0);
        chk("R9 no fault same cycle", {63'h0, wr_fault_o}, 64'h0);
        idle();
        chk("R9 fault next cycle", {63'h0, wr_fault_o}, 64'h1);
        idle();
        chk("R9 fault clears", {63'h0, wr_fault_o}, 64'h0);
        read_half(1'b0, "R9 low unchanged", model[31:0]);
        drive(32'h0, 1'b0, 1'b1, 1'b1, 32'hDEADBEEF, 1'b0);
        idle();
        read_half(1'b1, "R9 upper unchanged", model[63:32]);

        // R10: reset mid-run
        pwrite(1'b1, 32'hCAFE0000);
        drive(32'h0, 1'b0, 1'b1, 1'b0, 32'h1, 1'b0);
        @(negedge clk); rst = 1'b1; wr_en_i = 1'b0;
        @(negedge clk); rst = 1'b0; model = '0;
        #1;
        chk("R10 fault cleared by reset", {63'h0, wr_fault_o}, 64'h0);
        read_half(1'b1, "R10 counter cleared", 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule